// File: doc/BRIEF.md
# Per-Region Burst Flattening Bridge

This block sits on an AHB-style bus between a bus master and an external memory controller that serves four chip-select regions. Each region can be marked as holding plain peripherals. For a marked region, any burst is passed downstream as a string of independent non-sequential single transfers. Each beat still carries its own address, size and direction. Regions that are not marked see the master's transfers exactly as issued. The bridge adds no wait states. The downstream ready, response and read data go straight back to the master, and the write data goes straight through.

Software sets the per-region choice through a small register port that holds one mapping word. Out of reset every region is marked. This keeps external devices of unknown type reachable before any setup. The region of each beat is found from that beat's own address with a parameterised range compare. A burst that runs across a region boundary is therefore treated beat by beat.

Top module: `burst_split_bridge`

## Requirements
- R1: After synchronous reset the mapping word reads back as 0x0000000F, so all four regions are flattened.
- R2: The mapping word is at register offset 0x08. A read there (reg_sel=1, reg_wr=0) returns the four flag bits in bits 3..0 and zero in bits 31..4. A write there stores only bits 3..0. A read at any other offset, or while no read is active, returns zero.
- R3: Transfer codes are IDLE=00, BUSY=01, NONSEQ=10 and SEQ=11, and the SINGLE burst code is 000. For a beat whose region flag is 1, SEQ is sent downstream as NONSEQ and the burst code is forced to SINGLE.
- R4: For a beat whose region flag is 0, or whose address lies outside all four regions, the transfer code and the burst code are forwarded unchanged.
- R5: For a flattened region, IDLE stays IDLE and BUSY is sent downstream as IDLE.
- R6: Address, size and the write flag go downstream unchanged in the same cycle. Write data goes downstream unchanged in the same cycle. Ready, response and read data come back to the master unchanged in the same cycle.
- R7: The region is decoded per beat. Region n covers BASE + n*2^REGION_BITS up to the next region (defaults BASE=0x40000000, REGION_BITS=24). So a burst that crosses from a flattened region into an unflattened one changes treatment at the crossing beat.
- R8: A mapping write takes effect at the first address phase that starts after it. A beat held in its address phase by ready=0 keeps the treatment it started with, even when a write lands during the stall.
- R9: Flag bit n controls region n only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register port access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| m_haddr | input | 32 | Master address |
| m_htrans | input | 2 | Master transfer code |
| m_hburst | input | 3 | Master burst code |
| m_hsize | input | 3 | Master transfer size |
| m_hwrite | input | 1 | Master write flag |
| m_hwdata | input | DATA_W | Master write data |
| m_hrdata | output | DATA_W | Read data to the master |
| m_hready | output | 1 | Ready to the master |
| m_hresp | output | 1 | Response to the master |
| s_haddr | output | 32 | Downstream address |
| s_htrans | output | 2 | Downstream transfer code |
| s_hburst | output | 3 | Downstream burst code |
| s_hsize | output | 3 | Downstream transfer size |
| s_hwrite | output | 1 | Downstream write flag |
| s_hwdata | output | DATA_W | Downstream write data |
| s_hrdata | input | DATA_W | Downstream read data |
| s_hready | input | 1 | Downstream ready |
| s_hresp | input | 1 | Downstream response |

## Verification
Every bus output is a same-cycle function of the inputs and of the flag set in force. The bench therefore changes inputs on the falling edge and compares all outputs 2 ns later, in that same cycle, against a behavioural model. A mapping write is stored on the next rising edge. Its effect is due on the register read one cycle later, and on the first address phase that begins after ready was high. The model applies the write at that same rising edge, so the stalled-beat case and the following beat are each checked in their own cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BURST_SINGLE = 3'b000;

    typedef struct packed {
        logic [31:0] addr;
        trans_e      trans;
        logic [2:0]  burst;
        logic [2:0]  size;
        logic        write;
    } beat_t;

    // Flatten one address-phase beat when its region asks for it.
    function automatic beat_t flatten_beat(beat_t b, logic en);
        beat_t r;
        r = b;
        if (en) begin
            r.burst = BURST_SINGLE;
            case (b.trans)
                TR_SEQ:  r.trans = TR_NONSEQ;
                TR_BUSY: r.trans = TR_IDLE;
                default: r.trans = b.trans;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/bsc_map_reg.sv
module bsc_map_reg #(
    parameter int               NUM_CS     = 4,
    parameter int               REG_AW     = 8,
    parameter logic [REG_AW-1:0] MAP_OFFSET = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CS-1:0] map_q
);
    logic hit_off;
    logic unused_wbits;

    assign hit_off      = reg_sel && (reg_addr == MAP_OFFSET);
    assign unused_wbits = ^reg_wdata[31:NUM_CS];

    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '1;
        else if (hit_off && reg_wr)
            map_q <= reg_wdata[NUM_CS-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_off && !reg_wr)
            reg_rdata[NUM_CS-1:0] = map_q;
    end

    // R1: the first cycle after reset sees every region flattened
    assert_reset_all_on_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (map_q == '1));

    // R2: reserved bits never read as anything but zero
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:NUM_CS] == '0);

endmodule

// File: rtl/bsc_region_dec.sv
module bsc_region_dec #(
    parameter int          NUM_CS      = 4,
    parameter int          REGION_BITS = 24,
    parameter logic [31:0] BASE_ADDR   = 32'h4000_0000
) (
    input  logic [31:0]       addr,
    output logic [NUM_CS-1:0] hit
);
    localparam int IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam int TOP_LSB = REGION_BITS + IDX_W;

    logic in_window;
    logic unused_low;

    assign in_window  = (addr[31:TOP_LSB] == BASE_ADDR[31:TOP_LSB]);
    assign unused_low = ^addr[REGION_BITS-1:0];

    for (genvar n = 0; n < NUM_CS; n++) begin : g_rgn
        assign hit[n] = in_window &&
                        (addr[TOP_LSB-1:REGION_BITS] == IDX_W'(n));
    end

endmodule

// File: rtl/bsc_beat_rewrite.sv
module bsc_beat_rewrite
    import bsc_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  beat_t             beat_i,
    input  logic [NUM_CS-1:0] hit,
    input  logic [NUM_CS-1:0] mask,
    output beat_t             beat_o,
    output logic              conv_o
);
    assign conv_o = |(hit & mask);
    assign beat_o = flatten_beat(beat_i, conv_o);
endmodule

// File: rtl/burst_split_bridge.sv
module burst_split_bridge
    import bsc_pkg::*;
#(
    parameter int                NUM_CS      = 4,
    parameter int                DATA_W      = 32,
    parameter int                REGION_BITS = 24,
    parameter logic [31:0]       BASE_ADDR   = 32'h4000_0000,
    parameter int                REG_AW      = 8,
    parameter logic [REG_AW-1:0] MAP_OFFSET  = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       m_haddr,
    input  logic [1:0]        m_htrans,
    input  logic [2:0]        m_hburst,
    input  logic [2:0]        m_hsize,
    input  logic              m_hwrite,
    input  logic [DATA_W-1:0] m_hwdata,
    output logic [DATA_W-1:0] m_hrdata,
    output logic              m_hready,
    output logic              m_hresp,
    output logic [31:0]       s_haddr,
    output logic [1:0]        s_htrans,
    output logic [2:0]        s_hburst,
    output logic [2:0]        s_hsize,
    output logic              s_hwrite,
    output logic [DATA_W-1:0] s_hwdata,
    input  logic [DATA_W-1:0] s_hrdata,
    input  logic              s_hready,
    input  logic              s_hresp
);
    logic [NUM_CS-1:0] map_q, held_q, mask_live, hit;
    logic              hold_q, conv;
    beat_t             beat_in, beat_out;

    bsc_map_reg #(.NUM_CS(NUM_CS), .REG_AW(REG_AW), .MAP_OFFSET(MAP_OFFSET)) u_map (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .map_q(map_q)
    );

    // A beat stalled in its address phase keeps the flag set it began with.
    assign mask_live = hold_q ? held_q : map_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            held_q <= '1;
        end else begin
            hold_q <= !s_hready;
            held_q <= mask_live;
        end
    end

    bsc_region_dec #(.NUM_CS(NUM_CS), .REGION_BITS(REGION_BITS), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(m_haddr), .hit(hit)
    );

    assign beat_in = '{addr: m_haddr, trans: trans_e'(m_htrans), burst: m_hburst,
                       size: m_hsize, write: m_hwrite};

    bsc_beat_rewrite #(.NUM_CS(NUM_CS)) u_rw (
        .beat_i(beat_in), .hit(hit), .mask(mask_live),
        .beat_o(beat_out), .conv_o(conv)
    );

    assign s_haddr  = beat_out.addr;
    assign s_htrans = beat_out.trans;
    assign s_hburst = beat_out.burst;
    assign s_hsize  = beat_out.size;
    assign s_hwrite = beat_out.write;
    assign s_hwdata = m_hwdata;
    assign m_hrdata = s_hrdata;
    assign m_hready = s_hready;
    assign m_hresp  = s_hresp;

    // R3 / R5: a flattened beat never shows SEQ or BUSY downstream
    assert_conv_no_seq_R3: assert property (@(posedge clk) disable iff (rst)
        conv |-> (s_htrans == TR_IDLE || s_htrans == TR_NONSEQ));

    // R3: a flattened beat carries the SINGLE burst code
    assert_conv_single_R3: assert property (@(posedge clk) disable iff (rst)
        conv |-> (s_hburst == BURST_SINGLE));

    // R4: unflattened beats keep the master's codes
    assert_plain_same_R4: assert property (@(posedge clk) disable iff (rst)
        !conv |-> (s_htrans == m_htrans && s_hburst == m_hburst));

    // R8: while the address phase is stalled, the flag set stays fixed
    assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(s_hready)) |-> (mask_live == $past(mask_live)));

endmodule

// File: tb/sim_burst_split_bridge.sv
module sim_burst_split_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 0, reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [31:0] m_haddr = 0, m_hwdata = 0, m_hrdata;
    logic [1:0]  m_htrans = 0;
    logic [2:0]  m_hburst = 0, m_hsize = 0;
    logic        m_hwrite = 0, m_hready, m_hresp;
    logic [31:0] s_haddr, s_hwdata, s_hrdata = 0;
    logic [1:0]  s_htrans;
    logic [2:0]  s_hburst, s_hsize;
    logic        s_hwrite, s_hready = 1, s_hresp = 0;

    int checks = 0, fails = 0, seqn = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_split_bridge u0 (.*);

    // Behavioural reference: stored flags, plus the set frozen during a stall.
    bit [3:0] mdl_cfg = 4'hF, mdl_held = 4'hF;
    bit       mdl_hold = 0;
    always @(posedge clk) begin
        bit [3:0] live;
        if (rst) begin
            mdl_cfg = 4'hF; mdl_held = 4'hF; mdl_hold = 0;
        end else begin
            live = mdl_hold ? mdl_held : mdl_cfg;
            if (reg_sel && reg_wr && reg_addr == 8'h08) mdl_cfg = reg_wdata[3:0];
            mdl_held = live;
            mdl_hold = !s_hready;
        end
    end

    function automatic bit [77:0] expect_bus();
        bit [3:0] live = mdl_hold ? mdl_held : mdl_cfg;
        bit       en = 0;
        bit [1:0] t = m_htrans;
        bit [2:0] b = m_hburst;
        if (m_haddr[31:26] == 6'b010000) en = live[m_haddr[25:24]];
        if (en) begin
            b = 3'b000;
            if (t == 2'b11) t = 2'b10;
            else if (t == 2'b01) t = 2'b00;
        end
        return {m_haddr, t, b, m_hsize, m_hwrite, m_hwdata[15:0],
                s_hrdata[15:0], s_hready, s_hresp};
    endfunction

    task automatic check_bus(input string tag);
        bit [77:0] exp_v = expect_bus();
        bit [77:0] act_v = {s_haddr, s_htrans, s_hburst, s_hsize, s_hwrite, s_hwdata[15:0],
                            m_hrdata[15:0], m_hready, m_hresp};
        checks++;
        if (act_v !== exp_v || s_hwdata !== m_hwdata || m_hrdata !== s_hrdata) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic beat(input [31:0] a, input [1:0] t, input [2:0] b, input bit rdy,
                        input bit do_wr, input [31:0] wv, input string tag);
        @(negedge clk);
        seqn++;
        m_haddr = a; m_htrans = t; m_hburst = b; m_hsize = 3'd2; m_hwrite = seqn[1];
        m_hwdata = 32'hA500_0000 + seqn; s_hrdata = 32'h5A00_0000 + seqn * 3;
        s_hready = rdy; s_hresp = seqn[0];
        reg_sel = do_wr; reg_wr = do_wr; reg_addr = 8'h08; reg_wdata = wv;
        #2;
        check_bus(tag);
    endtask

    task automatic reg_read(input [7:0] off, input [31:0] exp_v, input string tag);
        @(negedge clk);
        m_htrans = 2'b00; s_hready = 1;
        reg_sel = 1; reg_wr = 0; reg_addr = off;
        #2;
        checks++;
        if (reg_rdata !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, reg_rdata, exp_v);
        end
        check_bus(tag);
    endtask

    localparam logic [31:0] R0 = 32'h4000_0000, R1A = 32'h4100_0000,
                            R2A = 32'h4200_0000, R3A = 32'h4300_0000;

    initial begin
        repeat (3) @(posedge clk);
        reg_read(8'h08, 32'h0000_000F, "R1 reset value during reset");
        @(negedge clk); rst = 0;
        reg_read(8'h08, 32'h0000_000F, "R1 reset value after release");
        // R3: flattening with all flags on (INCR4 = 011)
        beat(R0 + 32'h10, 2'b10, 3'b011, 1, 0, 0, "R3 first beat region0");
        beat(R0 + 32'h14, 2'b11, 3'b011, 1, 0, 0, "R3 seq beat region0");
        beat(R3A + 32'h40, 2'b11, 3'b101, 1, 0, 0, "R3 seq beat region3");
        // R2: write with reserved bits set, read back, other offsets
        beat(32'h0, 2'b00, 3'b000, 1, 1, 32'hFFFF_FFF5, "R2 mapping write");
        reg_read(8'h08, 32'h0000_0005, "R2 reserved bits read zero");
        reg_read(8'h04, 32'h0, "R2 other offset reads zero");
        reg_read(8'h0C, 32'h0, "R2 offset 0x0C reads zero");
        // R9 / R4: region1 and region3 now unflattened, region0 and region2 flattened
        beat(R1A + 32'h20, 2'b11, 3'b011, 1, 0, 0, "R4 region1 seq unaltered");
        beat(R3A + 32'h20, 2'b11, 3'b111, 1, 0, 0, "R9 region3 unaltered");
        beat(R2A + 32'h20, 2'b11, 3'b111, 1, 0, 0, "R9 region2 flattened");
        beat(32'h1000_0000, 2'b11, 3'b001, 1, 0, 0, "R4 outside all regions");
        // R5: idle and busy in a flattened region, busy in a plain one
        beat(R2A + 32'h24, 2'b01, 3'b011, 1, 0, 0, "R5 busy becomes idle");
        beat(R2A + 32'h24, 2'b00, 3'b011, 1, 0, 0, "R5 idle stays idle");
        beat(R1A + 32'h24, 2'b01, 3'b011, 1, 0, 0, "R5 busy kept in plain region");
        // R6: data and response paths with a stall and errors
        beat(R1A + 32'h28, 2'b10, 3'b000, 0, 0, 0, "R6 stalled passthrough");
        beat(R1A + 32'h28, 2'b10, 3'b000, 1, 0, 0, "R6 released passthrough");
        // R7: burst crossing region0 into region1
        beat(R1A - 32'h8, 2'b10, 3'b011, 1, 0, 0, "R7 crossing beat0 region0");
        beat(R1A - 32'h4, 2'b11, 3'b011, 1, 0, 0, "R7 crossing beat1 region0");
        beat(R1A,         2'b11, 3'b011, 1, 0, 0, "R7 crossing beat2 region1");
        beat(R1A + 32'h4, 2'b11, 3'b011, 1, 0, 0, "R7 crossing beat3 region1");
        // R8: write during a stalled beat in region0
        beat(R0 + 32'h30, 2'b11, 3'b011, 0, 1, 32'h0, "R8 stalled beat with write");
        beat(R0 + 32'h30, 2'b11, 3'b011, 1, 0, 0, "R8 stalled beat keeps treatment");
        beat(R0 + 32'h34, 2'b11, 3'b011, 1, 0, 0, "R8 next beat uses new flags");
        reg_read(8'h08, 32'h0, "R8 stored flags cleared");
        // R1 again: reset restores all flags
        @(negedge clk); rst = 1; reg_sel = 0;
        @(negedge clk); rst = 0;
        beat(R1A + 32'h44, 2'b11, 3'b011, 1, 0, 0, "R1 region1 flattened after reset");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule